// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache with Selective Invalidation

This block is a small, fully associative cache of completed address translations. Each slot maps a virtual page number to a physical page number and carries permission bits. Each slot is also tagged with an address-space identifier and a global flag. A combinational lookup port answers for the address space currently in force. A fill port installs leaf translations that a page-table walker has already resolved. A fence port removes slots, either by page, by address space, by both, or all at once.

The current address-space identifier is an input. Fills for any other address space are discarded unless they are marked global, so the cache never holds private translations of an inactive address space. A fill for a page and identifier already present replaces that slot. Any other accepted fill takes the next slot in round-robin order.

A parameter selects a reduced mode. In that mode every fence ignores its page and identifier operands and empties the whole cache.

Top module: `tlb_asid_fence`

## Requirements
- R1: After reset every slot is invalid, so every lookup misses.
- R2: A lookup hits when a valid slot has the requested virtual page and is either global or tagged with `cur_asid`. The hit, physical page and permission bits are returned in the same cycle from the registered state. When several slots hit, the lowest-numbered slot wins.
- R3: A fill is accepted only when `fill_global` is 1 or `fill_asid` equals `cur_asid`. Any other fill is dropped and leaves the cache unchanged.
- R4: An accepted fill whose page and identifier both equal those of a valid slot rewrites that slot and allocates no new one.
- R5: Any other accepted fill is written at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after the last slot, only when such an allocation happens.
- R6: A fence with `fen_addr_valid`=0 acts on every page. With `fen_addr_valid`=1 it acts only on slots whose page equals `fen_vpn`.
- R7: A fence with `fen_asid_valid`=0 acts on slots of every identifier, global slots included.
- R8: A fence with `fen_asid_valid`=1 removes only non-global slots tagged `fen_asid`. Global slots stay valid, also when `fen_asid` is 0.
- R9: A fence is applied at the next rising edge. A lookup in the fence cycle sees the old contents, and the next cycle sees the removal.
- R10: When a fill and a fence arrive in the same cycle, the fence is applied first and the fill afterwards. The newly filled translation therefore survives.
- R11: With `FENCE_ALL_ONLY`=1, every fence invalidates every slot, global ones included, whatever its page and identifier operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_asid | input | ASID_W | Identifier of the address space in force |
| lk_vpn | input | VPN_W | Virtual page being looked up |
| lk_hit | output | 1 | Lookup found a usable slot |
| lk_ppn | output | PPN_W | Physical page of the hitting slot |
| lk_perm | output | PERM_W | Permission bits of the hitting slot |
| fill_valid | input | 1 | Install request strobe |
| fill_vpn | input | VPN_W | Virtual page to install |
| fill_asid | input | ASID_W | Identifier of the translation to install |
| fill_global | input | 1 | Translation is shared by all address spaces |
| fill_ppn | input | PPN_W | Physical page to install |
| fill_perm | input | PERM_W | Permission bits to install |
| fen_valid | input | 1 | Fence request strobe |
| fen_addr_valid | input | 1 | 1: fence only `fen_vpn`; 0: all pages |
| fen_vpn | input | VPN_W | Page operand of the fence |
| fen_asid_valid | input | 1 | 1: fence only non-global slots of `fen_asid`; 0: every slot |
| fen_asid | input | ASID_W | Identifier operand of the fence |

## Verification
Some properties are checked on every cycle by the assertions:
- A dropped fill never raises the slot count.
- A full fence leaves nothing valid.
- An identifier-only fence keeps every global slot and clears every private slot of its identifier.
- The replacement pointer moves only on an allocation.
- In the reduced mode, any fence without a fill leaves the cache empty.

Other behaviour is visible only through the bench's scenarios:
- the translated values returned;
- the pre-fence view in the fence cycle;
- overwrite instead of duplication;
- eviction order;
- the fence-then-fill ordering when both arrive together.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;

    // Fence reach, encoded as {by_page, by_space}
    typedef enum logic [1:0] {
        SC_EVERY      = 2'b00,
        SC_SPACE      = 2'b01,
        SC_PAGE       = 2'b10,
        SC_PAGE_SPACE = 2'b11
    } fence_scope_e;

    function automatic fence_scope_e scope_of(input logic by_page, input logic by_space);
        return fence_scope_e'({by_page, by_space});
    endfunction

endpackage

// File: rtl/tlbf_slot_cmp.sv
module tlbf_slot_cmp
    import tlbf_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 9
) (
    input  logic              ent_vld,
    input  logic              ent_glb,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPN_W-1:0]  ent_vpn,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  fence_scope_e      fen_scope,
    input  logic [VPN_W-1:0]  fen_vpn,
    input  logic [ASID_W-1:0] fen_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    output logic              lk_match,
    output logic              fen_kill,
    output logic              fill_same
);

    logic page_eq;
    logic space_eq;

    always_comb begin
        page_eq  = (ent_vpn == fen_vpn);
        // global slots never belong to one address space
        space_eq = !ent_glb && (ent_asid == fen_asid);
        unique case (fen_scope)
            SC_EVERY:      fen_kill = ent_vld;
            SC_SPACE:      fen_kill = ent_vld && space_eq;
            SC_PAGE:       fen_kill = ent_vld && page_eq;
            SC_PAGE_SPACE: fen_kill = ent_vld && page_eq && space_eq;
            default:       fen_kill = ent_vld;
        endcase
        lk_match  = ent_vld && (ent_vpn == lk_vpn) && (ent_glb || (ent_asid == cur_asid));
        fill_same = (ent_vpn == fill_vpn) && (ent_asid == fill_asid);
    end

endmodule

// File: rtl/tlbf_rr_ptr.sv
module tlbf_rr_ptr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(ptr_q));

    a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/tlb_asid_fence.sv
module tlb_asid_fence
    import tlbf_pkg::*;
#(
    parameter int ENTRIES        = 8,
    parameter int VPN_W          = 20,
    parameter int PPN_W          = 22,
    parameter int ASID_W         = 9,
    parameter int PERM_W         = 4,
    parameter bit FENCE_ALL_ONLY = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ASID_W-1:0] cur_asid,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fen_valid,
    input  logic              fen_addr_valid,
    input  logic [VPN_W-1:0]  fen_vpn,
    input  logic              fen_asid_valid,
    input  logic [ASID_W-1:0] fen_asid
);

    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic              vld;
        logic              glb;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PERM_W-1:0] perm;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } state_t;

    state_t state_d, state_q;

    fence_scope_e        fen_scope;
    logic [ENTRIES-1:0]  kill_raw;
    logic [ENTRIES-1:0]  hit_vec;
    logic [ENTRIES-1:0]  same_vec;
    logic [ENTRIES-1:0]  vld_vec;
    logic [IDX_W-1:0]    rr_ptr;
    logic                fill_ok;
    logic                alloc;
    logic                same_hit;
    logic [IDX_W-1:0]    same_idx;
    logic [IDX_W-1:0]    tgt_idx;

    // Fence reach: the reduced mode collapses every form into a full flush
    generate
        if (FENCE_ALL_ONLY) begin : g_scope_full
            assign fen_scope = SC_EVERY;
        end else begin : g_scope_sel
            assign fen_scope = scope_of(fen_addr_valid, fen_asid_valid);
        end
    endgenerate

    // One comparator per slot
    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            tlbf_slot_cmp #(
                .VPN_W  (VPN_W),
                .ASID_W (ASID_W)
            ) u_cmp (
                .ent_vld   (state_q.slot[g].vld),
                .ent_glb   (state_q.slot[g].glb),
                .ent_asid  (state_q.slot[g].asid),
                .ent_vpn   (state_q.slot[g].vpn),
                .cur_asid  (cur_asid),
                .lk_vpn    (lk_vpn),
                .fen_scope (fen_scope),
                .fen_vpn   (fen_vpn),
                .fen_asid  (fen_asid),
                .fill_vpn  (fill_vpn),
                .fill_asid (fill_asid),
                .lk_match  (hit_vec[g]),
                .fen_kill  (kill_raw[g]),
                .fill_same (same_vec[g])
            );
            assign vld_vec[g] = state_q.slot[g].vld;
        end
    endgenerate

    tlbf_rr_ptr #(
        .ENTRIES (ENTRIES)
    ) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc),
        .ptr     (rr_ptr)
    );

    // Next state: fence first, then fill
    always_comb begin
        state_d  = state_q;
        fill_ok  = fill_valid && (fill_global || (fill_asid == cur_asid));
        same_hit = 1'b0;
        same_idx = '0;

        if (fen_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (kill_raw[i]) state_d.slot[i].vld = 1'b0;
            end
        end

        // A slot that survives the fence with the same page and identifier is reused
        for (int i = 0; i < ENTRIES; i++) begin
            if (!same_hit && state_d.slot[i].vld && same_vec[i]) begin
                same_hit = 1'b1;
                same_idx = IDX_W'(i);
            end
        end

        alloc   = fill_ok && !same_hit;
        tgt_idx = same_hit ? same_idx : rr_ptr;

        if (fill_ok) begin
            state_d.slot[tgt_idx].vld  = 1'b1;
            state_d.slot[tgt_idx].glb  = fill_global;
            state_d.slot[tgt_idx].asid = fill_asid;
            state_d.slot[tgt_idx].vpn  = fill_vpn;
            state_d.slot[tgt_idx].ppn  = fill_ppn;
            state_d.slot[tgt_idx].perm = fill_perm;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // Lookup: lowest-numbered hitting slot wins
    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!lk_hit && hit_vec[i]) begin
                lk_hit  = 1'b1;
                lk_ppn  = state_q.slot[i].ppn;
                lk_perm = state_q.slot[i].perm;
            end
        end
    end

    // R3: a refused or absent fill never adds a valid slot
    a_r3_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_ok |=> ($countones(vld_vec) <= $countones($past(vld_vec))));

    // R7: an unrestricted fence with no fill empties the cache
    a_r7_full_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fen_valid && !fen_addr_valid && !fen_asid_valid && !fill_valid) |=> (vld_vec == '0));

    generate
        if (FENCE_ALL_ONLY) begin : g_chk_full
            // R11: reduced mode ignores both operands
            a_r11_any_fence_flushes: assert property (@(posedge clk) disable iff (!rst_n)
                (fen_valid && !fill_valid) |=> (vld_vec == '0));
        end else begin : g_chk_sel
            for (genvar g = 0; g < ENTRIES; g++) begin : g_slot_chk
                // R8: global slots survive identifier-only fences
                a_r8_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
                    (fen_valid && fen_asid_valid && !fen_addr_valid
                     && state_q.slot[g].vld && state_q.slot[g].glb)
                    |=> state_q.slot[g].vld);
                // R8: private slots of the named identifier are removed
                a_r8_space_cleared: assert property (@(posedge clk) disable iff (!rst_n)
                    (fen_valid && fen_asid_valid && !fen_addr_valid && !fill_valid
                     && state_q.slot[g].vld && !state_q.slot[g].glb
                     && (state_q.slot[g].asid == fen_asid))
                    |=> !state_q.slot[g].vld);
            end
        end
    endgenerate

endmodule

// File: tb/tb_tlb_asid_fence.sv
module tb_tlb_asid_fence;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  cur_asid = '0;
    logic [19:0] lk_vpn = '0;
    logic        lk_hit, lk_hit_a;
    logic [21:0] lk_ppn, lk_ppn_a;
    logic [3:0]  lk_perm, lk_perm_a;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [8:0]  fill_asid = '0;
    logic        fill_global = 1'b0;
    logic [21:0] fill_ppn = '0;
    logic        fen_valid = 1'b0;
    logic        fen_addr_valid = 1'b0;
    logic [19:0] fen_vpn = '0;
    logic        fen_asid_valid = 1'b0;
    logic [8:0]  fen_asid = '0;

    int nchk = 0;
    int nfail = 0;

    always #2 clk = ~clk;

    tlb_asid_fence dut (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_ppn(fill_ppn), .fill_perm(fill_ppn[3:0]),
        .fen_valid(fen_valid), .fen_addr_valid(fen_addr_valid), .fen_vpn(fen_vpn),
        .fen_asid_valid(fen_asid_valid), .fen_asid(fen_asid)
    );

    tlb_asid_fence #(.FENCE_ALL_ONLY(1'b1)) dut_all (
        .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit_a), .lk_ppn(lk_ppn_a), .lk_perm(lk_perm_a),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_ppn(fill_ppn), .fill_perm(fill_ppn[3:0]),
        .fen_valid(fen_valid), .fen_addr_valid(fen_addr_valid), .fen_vpn(fen_vpn),
        .fen_asid_valid(fen_asid_valid), .fen_asid(fen_asid)
    );

    // op: 0 idle, 1 fill, 2 fence; expectations describe state before the op
    typedef struct packed {
        logic [3:0]  req;
        logic [8:0]  cur;
        logic [19:0] lvpn;
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [8:0]  asid;
        logic        g;
        logic        av;
        logic        sv;
        logic [21:0] ppn;
        logic        ehit;
        logic [21:0] eppn;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  9'd1, 20'h100, 2'd1, 20'h100, 9'd1, 1'b0, 1'b0, 1'b0, 22'hA1, 1'b0, 22'h0},  // R1
        '{4'd2,  9'd1, 20'h100, 2'd1, 20'h200, 9'd2, 1'b0, 1'b0, 1'b0, 22'hB2, 1'b1, 22'hA1}, // R2
        '{4'd3,  9'd2, 20'h200, 2'd1, 20'h300, 9'd5, 1'b1, 1'b0, 1'b0, 22'hC3, 1'b0, 22'h0},  // R3
        '{4'd3,  9'd2, 20'h300, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hC3}, // R3
        '{4'd2,  9'd2, 20'h100, 2'd1, 20'h100, 9'd2, 1'b0, 1'b0, 1'b0, 22'hD4, 1'b0, 22'h0},  // R2
        '{4'd2,  9'd1, 20'h100, 2'd1, 20'h100, 9'd1, 1'b0, 1'b0, 1'b0, 22'hE5, 1'b1, 22'hA1}, // R2
        '{4'd9,  9'd1, 20'h100, 2'd2, 20'h0,   9'd1, 1'b0, 1'b0, 1'b1, 22'h0,  1'b1, 22'hE5}, // R9, R4
        '{4'd9,  9'd1, 20'h100, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b0, 22'h0},  // R9
        '{4'd8,  9'd2, 20'h100, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hD4}, // R8
        '{4'd8,  9'd2, 20'h300, 2'd2, 20'h0,   9'd5, 1'b0, 1'b0, 1'b1, 22'h0,  1'b1, 22'hC3}, // R8
        '{4'd8,  9'd2, 20'h300, 2'd2, 20'h0,   9'd0, 1'b0, 1'b0, 1'b1, 22'h0,  1'b1, 22'hC3}, // R8
        '{4'd8,  9'd2, 20'h300, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hC3}, // R8
        '{4'd6,  9'd2, 20'h100, 2'd2, 20'h300, 9'd0, 1'b0, 1'b1, 1'b0, 22'h0,  1'b1, 22'hD4}, // R6
        '{4'd7,  9'd2, 20'h300, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b0, 22'h0},  // R7
        '{4'd6,  9'd2, 20'h100, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hD4}, // R6
        '{4'd2,  9'd2, 20'h100, 2'd1, 20'h400, 9'd2, 1'b0, 1'b0, 1'b0, 22'hF6, 1'b1, 22'hD4}, // R2
        '{4'd2,  9'd2, 20'h400, 2'd2, 20'h400, 9'd3, 1'b0, 1'b1, 1'b1, 22'h0,  1'b1, 22'hF6}, // R2
        '{4'd8,  9'd2, 20'h400, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hF6}, // R8
        '{4'd6,  9'd2, 20'h400, 2'd2, 20'h400, 9'd2, 1'b0, 1'b1, 1'b1, 22'h0,  1'b1, 22'hF6}, // R6
        '{4'd6,  9'd2, 20'h400, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b0, 22'h0},  // R6
        '{4'd7,  9'd2, 20'h100, 2'd2, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b1, 22'hD4}, // R7
        '{4'd7,  9'd2, 20'h100, 2'd0, 20'h0,   9'd0, 1'b0, 1'b0, 1'b0, 22'h0,  1'b0, 22'h0}   // R7
    };

    task automatic chk(input int req, input logic h, input logic [21:0] p, input logic [3:0] pm,
                       input logic eh, input logic [21:0] ep);
        logic ok;
        nchk++;
        ok = (h === eh) && (!eh || ((p === ep) && (pm === ep[3:0])));
        if (!ok) begin
            nfail++;
            $display("FAIL R%0d: hit=%0b ppn=%h perm=%h, expected hit=%0b ppn=%h perm=%h",
                     req, h, p, pm, eh, ep, ep[3:0]);
        end
    endtask

    task automatic probe(input int req, input logic [19:0] v, input logic eh, input logic [21:0] ep);
        lk_vpn = v;
        #1;
        chk(req, lk_hit, lk_ppn, lk_perm, eh, ep);
    endtask

    task automatic probe_all(input int req, input logic [19:0] v, input logic eh, input logic [21:0] ep);
        lk_vpn = v;
        #1;
        chk(req, lk_hit_a, lk_ppn_a, lk_perm_a, eh, ep);
    endtask

    // One-cycle operation: drive at a falling edge, release at the next
    task automatic step(input logic fv, input logic [19:0] fvpn, input logic [8:0] fas,
                        input logic fg, input logic [21:0] fp,
                        input logic ev, input logic av, input logic [19:0] evpn,
                        input logic sv, input logic [8:0] eas);
        @(negedge clk);
        fill_valid = fv; fill_vpn = fvpn; fill_asid = fas; fill_global = fg; fill_ppn = fp;
        fen_valid = ev; fen_addr_valid = av; fen_vpn = evpn; fen_asid_valid = sv; fen_asid = eas;
        @(negedge clk);
        fill_valid = 1'b0; fen_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fill_valid = 1'b0; fen_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cur_asid = VECS[i].cur;
            lk_vpn = VECS[i].lvpn;
            fill_valid = (VECS[i].op == 2'd1);
            fill_vpn = VECS[i].vpn; fill_asid = VECS[i].asid;
            fill_global = VECS[i].g; fill_ppn = VECS[i].ppn;
            fen_valid = (VECS[i].op == 2'd2);
            fen_addr_valid = VECS[i].av; fen_vpn = VECS[i].vpn;
            fen_asid_valid = VECS[i].sv; fen_asid = VECS[i].asid;
            #1;
            chk(int'(VECS[i].req), lk_hit, lk_ppn, lk_perm, VECS[i].ehit, VECS[i].eppn);
        end
        @(negedge clk);
        fill_valid = 1'b0; fen_valid = 1'b0;

        // R1: reset clears everything
        do_reset();
        cur_asid = 9'd3;
        probe(1, 20'h100, 1'b0, 22'h0);
        probe(1, 20'h300, 1'b0, 22'h0);

        // R4: second fill for the same page and identifier rewrites slot 0
        step(1'b1, 20'h10, 9'd3, 1'b0, 22'h111, 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        step(1'b1, 20'h10, 9'd3, 1'b0, 22'h122, 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        probe(4, 20'h10, 1'b1, 22'h122);

        // R5: seven more fills fill the cache, the next one evicts slot 0
        for (int k = 1; k <= 7; k++) begin
            step(1'b1, 20'(32'h10 + k), 9'd3, 1'b0, 22'(32'h200 + k), 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        end
        probe(5, 20'h10, 1'b1, 22'h122);
        step(1'b1, 20'h18, 9'd3, 1'b0, 22'h208, 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        probe(5, 20'h10, 1'b0, 22'h0);
        probe(5, 20'h11, 1'b1, 22'h201);
        probe(5, 20'h18, 1'b1, 22'h208);

        // R10: full fence and fill together, the fill survives
        step(1'b1, 20'h30, 9'd3, 1'b0, 22'h331, 1'b1, 1'b0, 20'h0, 1'b0, 9'd0);
        probe(10, 20'h11, 1'b0, 22'h0);
        probe(10, 20'h30, 1'b1, 22'h331);
        // R10: page fence of the very page being refilled
        step(1'b1, 20'h30, 9'd3, 1'b0, 22'h333, 1'b1, 1'b1, 20'h30, 1'b0, 9'd0);
        probe(10, 20'h30, 1'b1, 22'h333);

        // R11: reduced mode flushes on a narrow fence, full mode keeps both slots
        do_reset();
        cur_asid = 9'd3;
        step(1'b1, 20'h50, 9'd7, 1'b1, 22'h355, 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        step(1'b1, 20'h51, 9'd3, 1'b0, 22'h366, 1'b0, 1'b0, 20'h0, 1'b0, 9'd0);
        probe_all(11, 20'h50, 1'b1, 22'h355);
        step(1'b0, 20'h0, 9'd0, 1'b0, 22'h0, 1'b1, 1'b1, 20'h99, 1'b1, 9'd6);
        probe_all(11, 20'h50, 1'b0, 22'h0);
        probe_all(11, 20'h51, 1'b0, 22'h0);
        probe(11, 20'h50, 1'b1, 22'h355);
        probe(11, 20'h51, 1'b1, 22'h366);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule